// File: doc/BRIEF.md
# Serial BCD Multiplexed Display Scanner

This block turns a bit-serial stream of decimal digits into the drive signals for an eight-position multiplexed numeric display. Each digit arrives as four BCD bits, least significant bit first, at one accepted bit per clock. The block counts accepted bits in groups of four. At the end of each group it pulses a digit clock, which neighbouring units can use to stay aligned with the digit boundaries.

The stream is organised in frames of nine four-bit slots: eight digit slots and one idle slot. A one-hot ring steps the digit-select lines in step with the frame. After a digit slot completes, its select line is driven and the segments show that digit until the next boundary. After the idle slot completes, every select line and every segment is off.

The font has nine segments and curved digits. A zero is shown as a half-height glyph and is never blanked, including when it is a leading zero. The input is a valid/ready stream that never applies back-pressure. The block accepts a bit only in a cycle where the source holds valid high.

Top module: `serial_digit_scanner`

## Requirements
- R1: A bit is accepted on a rising clock edge where both s_valid and s_ready are high. s_ready is high in every cycle, so the block never back-pressures. The first accepted bit of a group is the BCD weight-1 bit and the fourth is the weight-8 bit.
- R2: dig_clk is high for exactly one cycle. That cycle follows the edge that accepted the fourth bit of a group, and dig_clk is low in every other cycle.
- R3: Slots run 0 to 8 in a repeating frame. In the cycle where dig_clk rises after slot k completes, for k from 0 to 7, dsel equals 1 << k, with bit 0 driving the first display position.
- R4: At most one bit of dsel is high in any cycle.
- R5: dsel and seg change only in cycles where dig_clk is high. They hold their values in all other cycles.
- R6: seg bit n drives segment a+n, so bit 0 is a and bit 8 is i. Digits 0 to 9 show these patterns:
  - 0: 0x05C
  - 1: 0x006
  - 2: 0x05B
  - 3: 0x04F
  - 4: 0x166
  - 5: 0x06D
  - 6: 0x0DD
  - 7: 0x087
  - 8: 0x07F
  - 9: 0x0EF
- R7: Segment f (bit 5) lights only for digits 4, 5, 8 and 9. Segment i (bit 8) lights only for digit 4.
- R8: Codes 10 to 15 show seg = 0, while the select line for their slot is still driven.
- R9: After the idle slot (slot 8) completes, dsel = 0 and seg = 0.
- R10: Zeros are never blanked. A zero in any slot, leading or not, shows pattern 0x05C.
- R11: rst is synchronous and active high. While it is asserted, dsel, seg and dig_clk are 0. Any partially received bits are discarded, and the next complete group after release is treated as slot 0.
- R12: A cycle with s_valid low has no effect. The s_bit value in that cycle is ignored, no bit is counted, and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Serial bit valid |
| s_ready | output | 1 | Always high; the block has no back-pressure |
| s_bit | input | 1 | Serial BCD data bit, LSB first within a digit |
| dig_clk | output | 1 | One-cycle pulse at each digit boundary |
| dsel | output | 8 | One-hot digit select lines; bit 0 is the first position |
| seg | output | 9 | Segment enables; bit 0 = a through bit 8 = i |

## Verification
The bench sends frames with a gap after some bits and holds s_bit at a changing value during those idle cycles. A design that counted unqualified cycles would then shift its digit boundaries and show scrambled codes on the wrong lines. Every one of the sixteen codes is sent, so a decoder that leaked patterns for codes 10 to 15 would show stray segments, and a wrong f or i term would light the tail of the 4 on other digits. The idle ninth slot is checked for a blank display, because a ring with eight stages instead of nine would wrap back onto the first line. A reset in the middle of a frame, with two bits already received, has to restart at the first line with no stale bits merged into the next digit.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int SEG_W = 9;
  typedef logic [SEG_W-1:0] seg_t;

  // Base font without segments f (bit 5) and i (bit 8); those are gate-decoded.
  function automatic seg_t font_base(input logic [3:0] code);
    seg_t p;
    case (code)
      4'd0: p = 9'h05C;
      4'd1: p = 9'h006;
      4'd2: p = 9'h05B;
      4'd3: p = 9'h04F;
      4'd4: p = 9'h046;
      4'd5: p = 9'h04D;
      4'd6: p = 9'h0DD;
      4'd7: p = 9'h087;
      4'd8: p = 9'h05F;
      4'd9: p = 9'h0CF;
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/ssd_bit_divider.sv
module ssd_bit_divider #(
  parameter int BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  output logic last,
  output logic dig_clk
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] TOP = CW'(BITS - 1);

  logic [CW-1:0] cnt;

  assign last = acc && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dig_clk <= 1'b0;
    end else begin
      dig_clk <= last;
      if (acc) cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssd_deser.sv
module ssd_deser #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         acc,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] sr;

  // LSB-first: the newest bit enters at the top and the oldest sits at bit 0.
  assign word = {bit_in, sr[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)      sr <= '0;
    else if (acc) sr <= {bit_in, sr[W-1:1]};
  end
endmodule

// File: rtl/ssd_scan.sv
module ssd_scan #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic         idle_slot,
  output logic [N-1:0] dsel
);
  // N digit stages plus one idle stage, seeded with a single one.
  logic [N:0] ring;

  assign idle_slot = ring[N];

  always_ff @(posedge clk) begin
    if (rst) begin
      ring <= {{N{1'b0}}, 1'b1};
      dsel <= '0;
    end else if (step) begin
      dsel <= ring[N-1:0];
      ring <= {ring[N-1:0], ring[N]};
    end
  end
endmodule

// File: rtl/ssd_seg_decode.sv
module ssd_seg_decode
  import ssd_pkg::*;
(
  input  logic [3:0] code,
  output seg_t       seg
);
  logic [3:0] t, c;
  logic       f_on, i_on;

  assign t = code;
  assign c = ~code;

  // f: 4,5 (0100,0101) and 8,9 (1000,1001)
  assign f_on = (c[3] & t[2] & c[1]) | (t[3] & c[2] & c[1]);
  // i: only 4 (0100)
  assign i_on = c[3] & t[2] & c[1] & c[0];

  always_comb begin
    seg    = font_base(code);
    seg[5] = f_on;
    seg[8] = i_on;
  end
endmodule

// File: rtl/serial_digit_scanner.sv
module serial_digit_scanner
  import ssd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIGIT_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic                  s_bit,
  output logic                  dig_clk,
  output logic [NUM_DIGITS-1:0] dsel,
  output logic [SEG_W-1:0]      seg
);
  logic                  acc;
  logic                  last;
  logic                  idle_slot;
  logic [DIGIT_BITS-1:0] word;
  seg_t                  seg_next;
  seg_t                  seg_q;

  assign s_ready = 1'b1;
  assign acc     = s_valid && s_ready;

  ssd_bit_divider #(.BITS(DIGIT_BITS)) u_div (
    .clk(clk), .rst(rst), .acc(acc), .last(last), .dig_clk(dig_clk)
  );

  ssd_deser #(.W(DIGIT_BITS)) u_deser (
    .clk(clk), .rst(rst), .acc(acc), .bit_in(s_bit), .word(word)
  );

  ssd_scan #(.N(NUM_DIGITS)) u_scan (
    .clk(clk), .rst(rst), .step(last), .idle_slot(idle_slot), .dsel(dsel)
  );

  ssd_seg_decode u_dec (
    .code(word[3:0]), .seg(seg_next)
  );

  always_ff @(posedge clk) begin
    if (rst)       seg_q <= '0;
    else if (last) seg_q <= idle_slot ? '0 : seg_next;
  end

  assign seg = seg_q;
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         s_ready,
  input logic         dig_clk,
  input logic [N-1:0] dsel,
  input logic [8:0]   seg
);
  AST_DSEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dsel)); // R4

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !dig_clk |-> ($stable(dsel) && $stable(seg))); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dig_clk |=> !dig_clk); // R2

  AST_TAIL_IMPLIES_F: assert property (@(posedge clk) disable iff (rst)
    seg[8] |-> seg[5]); // R7

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
    (dsel == '0) |-> (seg == '0)); // R9

  AST_NO_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    s_ready); // R1
endmodule

bind serial_digit_scanner ssd_checker #(.N(NUM_DIGITS)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .dig_clk(dig_clk),
  .dsel(dsel), .seg(seg)
);

// File: tb/tb_serial_digit_scanner.sv
module tb_serial_digit_scanner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s_valid = 1'b0;
  logic       s_bit = 1'b0;
  logic       s_ready;
  logic       dig_clk;
  logic [7:0] dsel;
  logic [8:0] seg;

  int n_chk = 0;
  int n_bad = 0;
  int exp_slot = 0;
  bit done = 0;
  logic [16:0] expq[$];

  always #2.5 clk = ~clk;

  serial_digit_scanner dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .dig_clk(dig_clk), .dsel(dsel), .seg(seg)
  );

  function automatic logic [8:0] font(input logic [3:0] d);
    case (d)
      4'd0: return 9'h05C;  4'd1: return 9'h006;  4'd2: return 9'h05B;
      4'd3: return 9'h04F;  4'd4: return 9'h166;  4'd5: return 9'h06D;
      4'd6: return 9'h0DD;  4'd7: return 9'h087;  4'd8: return 9'h07F;
      4'd9: return 9'h0EF;  default: return 9'h000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: pushes the expected display state, then sends four bits LSB first.
  task automatic send_digit(input logic [3:0] code, input int gap);
    logic [7:0] ed;
    logic [8:0] es;
    ed = (exp_slot < 8) ? (8'd1 << exp_slot) : 8'd0;
    es = (exp_slot < 8) ? font(code) : 9'd0;
    expq.push_back({ed, es});
    exp_slot = (exp_slot == 8) ? 0 : exp_slot + 1;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_bit   = code[b];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        s_valid = 1'b0;
        s_bit   = ~s_bit;  // R12: ignored while invalid
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Monitor: compares every digit boundary against the scoreboard.
  always @(negedge clk) begin
    if (!rst && dig_clk) begin
      if (expq.size() == 0) begin
        check("R2 unexpected dig_clk", 32'd1, 32'd0);
      end else begin
        logic [16:0] e;
        e = expq.pop_front();
        check("R3 dsel", {24'd0, dsel}, {24'd0, e[16:9]});
        check("R6 seg", {23'd0, seg}, {23'd0, e[8:0]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset dsel", {24'd0, dsel}, 32'd0);
    check("R11 reset seg", {23'd0, seg}, 32'd0);
    check("R11 reset dig_clk", {31'd0, dig_clk}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", {31'd0, s_ready}, 32'd1);

    // Frame 1: digits 0..7 and idle slot (R3, R6, R10, R9)
    for (int d = 0; d < 8; d++) send_digit(4'(d), 0);
    send_digit(4'd3, 0);
    check("R9 idle dsel", {24'd0, dsel}, 32'd0);
    check("R9 idle seg", {23'd0, seg}, 32'd0);

    // Frame 2: codes 8..15 with gaps (R8, R12, R7)
    for (int d = 8; d < 16; d++) send_digit(4'(d), (d % 3));
    send_digit(4'd9, 2);

    // Frame 3: leading zeros and digit 4 (R10, R7)
    send_digit(4'd0, 0); send_digit(4'd0, 1); send_digit(4'd4, 0);
    check("R7 tail of 4", {23'd0, seg}, 32'h166);
    check("R4 one line", {24'd0, dsel}, 32'h04);
    // R12: idle cycles with toggling data leave outputs unchanged
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      s_valid = 1'b0;
      s_bit   = k[0];
    end
    @(negedge clk);
    check("R12 hold dsel", {24'd0, dsel}, 32'h04);
    check("R12 hold seg", {23'd0, seg}, 32'h166);
    send_digit(4'd5, 0); send_digit(4'd8, 0);

    // R11: reset mid-frame with two stray bits pending
    @(negedge clk); s_valid = 1'b1; s_bit = 1'b1;
    @(negedge clk); s_valid = 1'b1; s_bit = 1'b1;
    @(negedge clk); s_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 mid reset dsel", {24'd0, dsel}, 32'd0);
    check("R11 mid reset seg", {23'd0, seg}, 32'd0);
    expq.delete();
    exp_slot = 0;
    rst = 1'b0;
    send_digit(4'd2, 0);
    check("R11 restart D1", {24'd0, dsel}, 32'h01);
    check("R11 restart seg", {23'd0, seg}, 32'h05B);
    for (int d = 1; d < 9; d++) send_digit(4'(9 - d), 0);

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", expq.size(), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule